// File: doc/BRIEF.md
# Twin-Port Synchronous RAM

This block is a memory with two fully independent access ports, called left and right. Both ports sit on one clock. Each port has its own address, write data, read data, read/write level, output enable, semaphore select, and a pair of chip enables. The two chip enables have opposite polarity.

A small decoder on each port turns its control pins into one access mode. The modes are: deselected, array write, array read, outputs quiet, flag write, flag read, and a refused combination. Read data comes out of a register one cycle after the request. A separate drive flag per port stands in for the tri-state enable of a bidirectional data bus. When the drive flag is low, the read data is forced to zero.

The semaphore path reaches a bank of eight single-bit flags instead of the main array. It is used with the chip enables inactive. Writes to a flag take data bit 0. Reads copy the flag onto every data bit. Same-address conflicts between the ports are settled by a fixed rule: the left port wins on write, and a read sees the old word.

Top module: `twin_port_ram`

## Requirements
- R1: A port is selected only when its `Ce0N` input is 0 and its `Ce1` input is 1. When the port is not selected and `SemN` is 1, the port does nothing. It writes nothing, and on the next cycle `Drive` is 0.
- R2: With the port selected, `SemN`=1 and `Rw`=0, the port stores `WrData` at `Addr`, whatever `OeN` is. On the next cycle `Drive` is 0.
- R3: With the port selected, `SemN`=1, `Rw`=1 and `OeN`=0, the next cycle shows `Drive`=1 and `RdData` equal to the word at `Addr`.
- R4: With `OeN`=1, `Drive` is 0 on the next cycle, whatever the level of `Rw`.
- R5: Both ports may read the same address in the same cycle, and both return the same word.
- R6: If both ports write the same address in one cycle, the left port's data is kept.
- R7: If one port reads an address while the other port writes it, the read returns the word held before that write.
- R8: With the port not selected and `SemN`=0, the port reaches flag number `Addr[2:0]` and never the array. With `Rw`=0, the flag takes `WrData[0]`. With `Rw`=1 and `OeN`=0, the next cycle shows `Drive`=1 and all nine `RdData` bits equal to that flag.
- R9: With the port selected and `SemN`=0 at the same time, the combination is refused. Neither the array nor the flags change, and on the next cycle `Drive` is 0.
- R10: After reset, `Drive` and `RdData` are 0 on both ports, and every flag reads 1.
- R11: If both ports write the same flag in one cycle, the left port's bit is kept.
- R12: Whenever `Drive` is 0, `RdData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of outputs and flags |
| lCe0N | input | 1 | Left chip enable, active low |
| lCe1 | input | 1 | Left chip enable, active high |
| lSemN | input | 1 | Left semaphore select, active low |
| lRw | input | 1 | Left read (1) / write (0) |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | ADDR_W | Left word address |
| lWrData | input | DATA_W | Left write data |
| lRdData | output | DATA_W | Left registered read data |
| lDrive | output | 1 | Left bus-drive flag (models tri-state enable) |
| rCe0N | input | 1 | Right chip enable, active low |
| rCe1 | input | 1 | Right chip enable, active high |
| rSemN | input | 1 | Right semaphore select, active low |
| rRw | input | 1 | Right read (1) / write (0) |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | ADDR_W | Right word address |
| rWrData | input | DATA_W | Right write data |
| rRdData | output | DATA_W | Right registered read data |
| rDrive | output | 1 | Right bus-drive flag (models tri-state enable) |

## Verification
The bench drives the four chip-enable combinations with a write pending. A decoder that accepted either enable alone would corrupt the word read back afterwards. It also forces same-address write collisions on both the array and the flags. A design that gave priority to the right port, or that let the two writes merge, would return the right port's value. Read-during-write across the ports is targeted, where a write-first memory would leak the new word. So is the selected-plus-semaphore combination, which a loose decoder would turn into an array or flag write. A randomised stretch over a 16-word window then mixes all modes against a behavioural model on every cycle.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_WRITE,
    MODE_READ,
    MODE_QUIET,
    MODE_FLAG_WR,
    MODE_FLAG_RD,
    MODE_CLASH
  } portMode_t;

  typedef struct packed {
    logic arrWr;
    logic arrRd;
    logic flagWr;
    logic flagRd;
  } portStrobe_t;

endpackage

// File: rtl/tpr_port_decode.sv
module tpr_port_decode
  import tpr_pkg::*;
(
  input  logic        ce0N,
  input  logic        ce1,
  input  logic        semN,
  input  logic        rw,
  input  logic        oeN,
  output portStrobe_t strobe
);

  logic      selected;
  portMode_t mode;

  assign selected = !ce0N && ce1;

  always_comb begin
    if (selected) begin
      if (!semN)      mode = MODE_CLASH;
      else if (!rw)   mode = MODE_WRITE;
      else if (!oeN)  mode = MODE_READ;
      else            mode = MODE_QUIET;
    end else if (!semN) begin
      if (!rw)        mode = MODE_FLAG_WR;
      else if (!oeN)  mode = MODE_FLAG_RD;
      else            mode = MODE_QUIET;
    end else begin
      mode = MODE_IDLE;
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.arrWr  = (mode == MODE_WRITE);
    strobe.arrRd  = (mode == MODE_READ);
    strobe.flagWr = (mode == MODE_FLAG_WR);
    strobe.flagRd = (mode == MODE_FLAG_RD);
  end

endmodule

// File: rtl/tpr_datapath.sv
module tpr_datapath
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9,
  parameter int FLAG_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  portStrobe_t [1:0]            strobe,
  input  logic [1:0][ADDR_W-1:0]       addr,
  input  logic [1:0][DATA_W-1:0]       wrData,
  output logic [1:0][DATA_W-1:0]       rdData,
  output logic [1:0]                   drive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NFLAGS = 1 << FLAG_W;
  localparam int LEFT   = 0;
  localparam int RIGHT  = 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [NFLAGS-1:0] flags;
  logic [1:0][FLAG_W-1:0] flagIdx;
  logic sameWordWr;
  logic sameFlagWr;

  always_comb begin
    for (int p = 0; p < 2; p++) flagIdx[p] = addr[p][FLAG_W-1:0];
  end

  assign sameWordWr = strobe[LEFT].arrWr && (addr[LEFT] == addr[RIGHT]);
  assign sameFlagWr = strobe[LEFT].flagWr && (flagIdx[LEFT] == flagIdx[RIGHT]);

  // Array writes: left port owns a shared address.
  always_ff @(posedge clk) begin
    if (strobe[RIGHT].arrWr && !sameWordWr) mem[addr[RIGHT]] <= wrData[RIGHT];
    if (strobe[LEFT].arrWr)                 mem[addr[LEFT]]  <= wrData[LEFT];
  end

  // Flag bank: reset to all ones, left port owns a shared flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '1;
    end else begin
      if (strobe[RIGHT].flagWr && !sameFlagWr) flags[flagIdx[RIGHT]] <= wrData[RIGHT][0];
      if (strobe[LEFT].flagWr)                 flags[flagIdx[LEFT]]  <= wrData[LEFT][0];
    end
  end

  // Registered read path per port, old-data semantics on collision.
  for (genvar p = 0; p < 2; p++) begin : g_read
    always_ff @(posedge clk) begin
      if (!rstN) begin
        drive[p]  <= 1'b0;
        rdData[p] <= '0;
      end else if (strobe[p].arrRd) begin
        drive[p]  <= 1'b1;
        rdData[p] <= mem[addr[p]];
      end else if (strobe[p].flagRd) begin
        drive[p]  <= 1'b1;
        rdData[p] <= {DATA_W{flags[flagIdx[p]]}};
      end else begin
        drive[p]  <= 1'b0;
        rdData[p] <= '0;
      end
    end
  end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9,
  parameter int FLAG_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe0N,
  input  logic              lCe1,
  input  logic              lSemN,
  input  logic              lRw,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lDrive,
  input  logic              rCe0N,
  input  logic              rCe1,
  input  logic              rSemN,
  input  logic              rRw,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rDrive
);

  logic [1:0] ce0N, ce1, semN, rw, oeN, drive;
  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0][DATA_W-1:0] wrData, rdData;
  portStrobe_t [1:0] strobe;

  assign ce0N   = {rCe0N, lCe0N};
  assign ce1    = {rCe1,  lCe1};
  assign semN   = {rSemN, lSemN};
  assign rw     = {rRw,   lRw};
  assign oeN    = {rOeN,  lOeN};
  assign addr   = {rAddr, lAddr};
  assign wrData = {rWrData, lWrData};

  for (genvar p = 0; p < 2; p++) begin : g_port
    tpr_port_decode u_dec (
      .ce0N   (ce0N[p]),
      .ce1    (ce1[p]),
      .semN   (semN[p]),
      .rw     (rw[p]),
      .oeN    (oeN[p]),
      .strobe (strobe[p])
    );
  end

  tpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .drive  (drive)
  );

  assign lRdData = rdData[0];
  assign rRdData = rdData[1];
  assign lDrive  = drive[0];
  assign rDrive  = drive[1];

endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              lCe0N,
  input logic              lCe1,
  input logic              lSemN,
  input logic              lRw,
  input logic              lOeN,
  input logic [ADDR_W-1:0] lAddr,
  input logic [DATA_W-1:0] lRdData,
  input logic              lDrive,
  input logic              rCe0N,
  input logic              rCe1,
  input logic              rSemN,
  input logic              rRw,
  input logic              rOeN,
  input logic [ADDR_W-1:0] rAddr,
  input logic [DATA_W-1:0] rRdData,
  input logic              rDrive
);

  logic lSel, rSel;
  assign lSel = !lCe0N && lCe1;
  assign rSel = !rCe0N && rCe1;

  // R1
  l_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lSel && lSemN) |=> !lDrive);
  // R1
  r_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rSel && rSemN) |=> !rDrive);
  // R2
  l_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lSel && lSemN && !lRw) |=> !lDrive);
  // R4
  l_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    lOeN |=> !lDrive);
  // R4
  r_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    rOeN |=> !rDrive);
  // R9
  l_clash_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lSel && !lSemN) |=> !lDrive);
  // R5
  same_word_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lSel && lSemN && lRw && !lOeN && rSel && rSemN && rRw && !rOeN && lAddr == rAddr)
    |=> (lRdData == rRdData) && lDrive && rDrive);
  // R12
  l_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lDrive |-> (lRdData == '0));
  // R12
  r_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rDrive |-> (rRdData == '0));

endmodule

bind twin_port_ram tpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .lCe0N(lCe0N), .lCe1(lCe1), .lSemN(lSemN), .lRw(lRw), .lOeN(lOeN),
  .lAddr(lAddr), .lRdData(lRdData), .lDrive(lDrive),
  .rCe0N(rCe0N), .rCe1(rCe1), .rSemN(rSemN), .rRw(rRw), .rOeN(rOeN),
  .rAddr(rAddr), .rRdData(rRdData), .rDrive(rDrive)
);

// File: tb/twin_port_ram_bench.sv
`timescale 1ns/1ps
module twin_port_ram_bench;

  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic pCe0N[2], pCe1[2], pSemN[2], pRw[2], pOeN[2];
  logic [AW-1:0] pAddr[2];
  logic [DW-1:0] pWr[2];
  logic [DW-1:0] lRdData, rRdData;
  logic lDrive, rDrive;

  twin_port_ram u_twin_port_ram (
    .clk(clk), .rstN(rstN),
    .lCe0N(pCe0N[0]), .lCe1(pCe1[0]), .lSemN(pSemN[0]), .lRw(pRw[0]), .lOeN(pOeN[0]),
    .lAddr(pAddr[0]), .lWrData(pWr[0]), .lRdData(lRdData), .lDrive(lDrive),
    .rCe0N(pCe0N[1]), .rCe1(pCe1[1]), .rSemN(pSemN[1]), .rRw(pRw[1]), .rOeN(pOeN[1]),
    .rAddr(pAddr[1]), .rWrData(pWr[1]), .rRdData(rRdData), .rDrive(rDrive)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int memModel [int];
  bit [7:0] flagModel;
  bit expDrive[2];
  bit expKnown[2];
  logic [DW-1:0] expData[2];
  string expTag[2];
  string tagOverride = "";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic setPort(int p, bit c0n, bit c1, bit sn, bit rwv, bit oen,
                         int a, int d);
    pCe0N[p] = c0n; pCe1[p] = c1; pSemN[p] = sn; pRw[p] = rwv; pOeN[p] = oen;
    pAddr[p] = AW'(a); pWr[p] = DW'(d);
  endtask

  task automatic idle(int p);     setPort(p, 1, 0, 1, 1, 1, 0, 0); endtask
  task automatic wr(int p, int a, int d); setPort(p, 0, 1, 1, 0, 1, a, d); endtask
  task automatic rd(int p, int a); setPort(p, 0, 1, 1, 1, 0, a, 0); endtask
  task automatic fwr(int p, int a, int d); setPort(p, 1, 0, 0, 0, 1, a, d); endtask
  task automatic frd(int p, int a); setPort(p, 1, 0, 0, 1, 0, a, 0); endtask

  task automatic checkOut(string tag, int p, bit d, logic [DW-1:0] q);
    checks++;
    if (d !== expDrive[p]) begin
      errors++;
      $display("FAIL %s port%0d drive: actual %0b expected %0b", tag, p, d, expDrive[p]);
    end
    if (expDrive[p] && expKnown[p]) begin
      checks++;
      if (q !== expData[p]) begin
        errors++;
        $display("FAIL %s port%0d data: actual %h expected %h", tag, p, q, expData[p]);
      end
    end else if (!expDrive[p]) begin
      checks++;
      if (q !== '0) begin
        errors++;
        $display("FAIL R12 port%0d idle data: actual %h expected 0", p, q);
      end
    end
  endtask

  // Behavioural model: evaluate one cycle, then advance the clock and compare.
  task automatic step();
    bit doWr[2], doFw[2];
    for (int p = 0; p < 2; p++) begin
      bit sel = (pCe0N[p] == 0) && (pCe1[p] == 1);
      int a = int'(pAddr[p]);
      doWr[p] = 0; doFw[p] = 0;
      expDrive[p] = 0; expKnown[p] = 1; expData[p] = '0;
      if (sel && !pSemN[p]) expTag[p] = "R9";
      else if (sel && !pRw[p]) begin expTag[p] = "R2"; doWr[p] = 1; end
      else if (sel && !pOeN[p]) begin
        expTag[p] = "R3"; expDrive[p] = 1;
        expKnown[p] = memModel.exists(a);
        if (expKnown[p]) expData[p] = DW'(memModel[a]);
      end
      else if (sel) expTag[p] = "R4";
      else if (!pSemN[p] && !pRw[p]) begin expTag[p] = "R8"; doFw[p] = 1; end
      else if (!pSemN[p] && !pOeN[p]) begin
        expTag[p] = "R8"; expDrive[p] = 1;
        expData[p] = {DW{flagModel[a % 8]}};
      end
      else if (!pSemN[p]) expTag[p] = "R4";
      else expTag[p] = "R1";
    end
    for (int p = 1; p >= 0; p--) begin
      if (doWr[p]) memModel[int'(pAddr[p])] = int'(pWr[p]);
      if (doFw[p]) flagModel[int'(pAddr[p]) % 8] = pWr[p][0];
    end
    @(posedge clk);
    @(negedge clk);
    checkOut(tagOverride != "" ? tagOverride : expTag[0], 0, lDrive, lRdData);
    checkOut(tagOverride != "" ? tagOverride : expTag[1], 1, rDrive, rRdData);
    tagOverride = "";
  endtask

  initial begin
    idle(0); idle(1);
    flagModel = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: outputs quiet right after reset
    checks++;
    if (lDrive !== 1'b0 || rDrive !== 1'b0 || lRdData !== '0 || rRdData !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs: actual %b%b %h %h expected 00 0 0",
               lDrive, rDrive, lRdData, rRdData);
    end
    // R10: every flag reads one after reset
    tagOverride = "R10"; frd(0, 5); frd(1, 2); step();
    idle(0); idle(1); step();

    wr(0, 3, 9'h1A5); step();                            // R2
    rd(0, 3); step();                                    // R3
    tagOverride = "R5"; rd(0, 3); rd(1, 3); step();      // R5
    tagOverride = "R6"; wr(0, 7, 9'h0AA); wr(1, 7, 9'h155); step();
    tagOverride = "R6"; rd(0, 7); rd(1, 7); step();
    tagOverride = "R7"; wr(0, 3, 9'h033); rd(1, 3); step();
    tagOverride = "R7"; rd(1, 3); idle(0); step();

    setPort(0, 0, 1, 1, 1, 1, 3, 0); idle(1); step();    // R4 read with OeN high
    setPort(0, 0, 1, 1, 0, 0, 4, 9'h0F0); step();        // R4 write with OeN low
    rd(0, 4); step();

    // R1: every non-selecting enable pair with a write pending
    setPort(0, 1, 1, 1, 0, 0, 4, 9'h111); step();
    setPort(0, 0, 0, 1, 0, 0, 4, 9'h122); step();
    setPort(0, 1, 0, 1, 0, 0, 4, 9'h133); step();
    tagOverride = "R1"; rd(0, 4); step();

    // R9: selected and semaphore together change nothing
    wr(1, 2, 9'h05A); idle(0); step(); idle(1);
    setPort(0, 0, 1, 0, 0, 1, 2, 9'h000); step();
    tagOverride = "R9"; rd(0, 2); frd(1, 2); step();

    // R8: flag path leaves the array alone
    fwr(0, 2, 9'h1FE); idle(1); step();
    tagOverride = "R8"; frd(1, 2); rd(0, 2); step();

    // R11: both ports write one flag
    tagOverride = "R11"; fwr(0, 4, 9'h000); fwr(1, 4, 9'h001); step();
    tagOverride = "R11"; frd(0, 4); frd(1, 12); step();

    // Mixed random traffic over a small window
    for (int i = 0; i < 16; i++) begin wr(0, i, i * 29); idle(1); step(); end
    for (int i = 0; i < 600; i++) begin
      for (int p = 0; p < 2; p++) begin
        int k = $urandom_range(0, 9);
        int a = $urandom_range(0, 15);
        int d = $urandom_range(0, 511);
        case (k)
          0, 1:    wr(p, a, d);
          2, 3, 4: rd(p, a);
          5:       fwr(p, a, d);
          6:       frd(p, a);
          7:       setPort(p, 0, 1, 0, $urandom_range(0, 1), $urandom_range(0, 1), a, d);
          8:       setPort(p, $urandom_range(0, 1), 0, 1, $urandom_range(0, 1), 0, a, d);
          default: setPort(p, 0, 1, 1, $urandom_range(0, 1), 1, a, d);
        endcase
      end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule